// File: doc/BRIEF.md
# Multi-DSP Channel Configuration Checker

This block examines how a four-lane DSP engine has been set up and reports one 5-bit error code. Code 0 means the setup is valid. Its inputs are a channel operating mode, one enable per lane, one mono flag per lane and one chunk-size field per lane. The mode decides how the lanes are grouped. Lanes can be checked one at a time, in pairs, as a group of three plus one single lane, or as a group of all four. Each grouping has its own rules on enables, mono settings and chunk sizes, and each rule that fails has its own code. The input and output directions each use one copy of the block, and both copies share the same code table.

The result is registered, so it follows the inputs one clock later. There is no sticky state: when the setup is corrected, the code returns to 0 on the next clock. When every lane is disabled, the output is 0 whatever the other inputs hold.

Each chunk field holds the chunk size as a plain binary number. The only sizes the rules look at are 8 and 16.

Top module: `dsp_cfg_checker`

## Requirements
- R1: `err_code_o` is a register. It is 0 while `rst` is high, and otherwise it shows the code for the inputs sampled at the previous rising clock edge.
- R2: When `en_i` is 4'b0000, the output is 0 one clock later, whatever the mode, mono and chunk inputs are.
- R3: In mode 0, each lane n is checked alone and reports code n+1 (codes 1 to 4) when its chunk is 16, or when its chunk is 8 and its mono flag is 1. This rule does not look at the lane's enable.
- R4: In mode 1, lanes 0 and 1 form a pair. The pair reports code 5 if either lane is disabled, code 6 if mono0=1 while mono1=0, and code 7 if chunk0=16.
- R5: In mode 1, lanes 2 and 3 each use the single-lane rule of R3, with code 8 for lane 2 and code 9 for lane 3.
- R6: In mode 2, pair 0/1 uses codes 10, 11 and 12, and pair 2/3 uses codes 13, 14 and 15. For each pair the three codes are, in order, a disabled lane, a lower-lane mono flag of 1 with an upper-lane mono flag of 0, and a lower-lane chunk of 16. The upper lane's chunk is not checked.
- R7: In mode 3, lanes 0, 1 and 2 form a triple. The triple reports code 16 if any of them is disabled, code 17 if mono0=1 while mono1 or mono2 is 0, and code 18 if chunk0=16. Lane 3 uses the single-lane rule with code 19, and its enable is not checked.
- R8: In mode 4, all four lanes are grouped. Code 20 is reported if any lane is disabled, and code 21 if mono0=1 while any other mono flag is 0. Chunk sizes are not checked in this mode.
- R9: When several rules fail at the same time, the lowest-numbered code is reported.
- R10: Mode values 5 to 7 report code 31, provided at least one lane is enabled.
- R11: A valid setup reports 0, and an error code returns to 0 on the clock after the setup is corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Channel operating mode |
| en_i | input | 4 | Lane enables, bit n for lane n |
| mono_i | input | 4 | Lane mono flags, bit n for lane n |
| chunk_i | input | 20 | Chunk sizes, 5 bits per lane, lane n at bits [5n+4:5n] |
| err_code_o | output | 5 | Registered error code (0 = valid) |

## Verification
The interesting cases are the ones where two rules fail in the same cycle. The bench builds such setups on purpose: a lower-lane mono mismatch together with a chunk of 16, two single lanes with bad chunks, and a disabled pair lane together with a bad chunk. Each of these must report the lower code. A second kind of collision is the all-disabled override meeting a reserved mode or a bad chunk, and there the output must be 0. The scoreboard compares every such vector one clock after it is applied, so it also catches a code that arrives a cycle early or late.

// File: rtl/dsp_cfgchk_pkg.sv
package dsp_cfgchk_pkg;

    localparam int NUM_LANES  = 4;
    localparam int MODE_W     = 3;
    localparam int CHUNK_W    = 5;
    localparam int CODE_W     = 5;
    localparam int CODE_SLOTS = 1 << CODE_W;
    localparam int CHUNK_BIG  = 16;
    localparam int CHUNK_MID  = 8;
    localparam int MODE_MAX   = 4;

    typedef enum logic [CODE_W-1:0] {
        CFG_OK       = 5'd0,
        M0_L0        = 5'd1,
        M0_L1        = 5'd2,
        M0_L2        = 5'd3,
        M0_L3        = 5'd4,
        M1_P01_EN    = 5'd5,
        M1_P01_MONO  = 5'd6,
        M1_P01_CHK   = 5'd7,
        M1_L2        = 5'd8,
        M1_L3        = 5'd9,
        M2_P01_EN    = 5'd10,
        M2_P01_MONO  = 5'd11,
        M2_P01_CHK   = 5'd12,
        M2_P23_EN    = 5'd13,
        M2_P23_MONO  = 5'd14,
        M2_P23_CHK   = 5'd15,
        M3_T012_EN   = 5'd16,
        M3_T012_MONO = 5'd17,
        M3_T012_CHK  = 5'd18,
        M3_L3        = 5'd19,
        M4_Q_EN      = 5'd20,
        M4_Q_MONO    = 5'd21,
        CFG_RSVD     = 5'd31
    } cfg_code_e;

    typedef struct packed {
        logic en_fail;
        logic mono_fail;
        logic chunk_fail;
    } grp_fail_t;

    typedef logic [CHUNK_W-1:0] chunk_t;

    function automatic logic lane_rule_bad(input logic mono, input chunk_t chunk);
        return (chunk == chunk_t'(CHUNK_BIG)) || ((chunk == chunk_t'(CHUNK_MID)) && mono);
    endfunction

endpackage

// File: rtl/dsp_cfgchk_lane.sv
module dsp_cfgchk_lane
    import dsp_cfgchk_pkg::*;
(
    input  logic   mono_i,
    input  chunk_t chunk_i,
    output logic   bad_o
);
    always_comb begin
        bad_o = lane_rule_bad(mono_i, chunk_i);
    end
endmodule

// File: rtl/dsp_cfgchk_group.sv
module dsp_cfgchk_group
    import dsp_cfgchk_pkg::*;
#(
    parameter int SIZE        = 2,
    parameter bit CHECK_CHUNK = 1'b1
) (
    input  logic [SIZE-1:0] en_i,
    input  logic [SIZE-1:0] mono_i,
    input  chunk_t          chunk_lo_i,
    output grp_fail_t       fail_o
);
    logic upper_mono_all;

    always_comb begin
        upper_mono_all = 1'b1;
        for (int i = 1; i < SIZE; i++) begin
            upper_mono_all = upper_mono_all & mono_i[i];
        end
        fail_o.en_fail   = ~(&en_i);
        fail_o.mono_fail = mono_i[0] & ~upper_mono_all;
    end

    generate
        if (CHECK_CHUNK) begin : g_chunk
            always_comb fail_o.chunk_fail = (chunk_lo_i == chunk_t'(CHUNK_BIG));
        end else begin : g_nochunk
            logic unused_chunk;
            always_comb unused_chunk = ^chunk_lo_i;
            always_comb fail_o.chunk_fail = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dsp_cfgchk_prio.sv
module dsp_cfgchk_prio #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 1; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    // R9: the chosen slot is set and no lower slot is set
    always_comb begin
        if (idx_o != '0) begin
            a_r9_lowest_set: assert (vec_i[idx_o] && ((vec_i & ((WIDTH'(1) << idx_o) - WIDTH'(1))) <= WIDTH'(1)));
        end
    end
endmodule

// File: rtl/dsp_cfg_checker.sv
module dsp_cfg_checker
    import dsp_cfgchk_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [MODE_W-1:0]              mode_i,
    input  logic [NUM_LANES-1:0]           en_i,
    input  logic [NUM_LANES-1:0]           mono_i,
    input  logic [NUM_LANES*CHUNK_W-1:0]   chunk_i,
    output logic [CODE_W-1:0]              err_code_o
);
    chunk_t                  chunk_a [NUM_LANES];
    logic [NUM_LANES-1:0]    lane_bad;
    grp_fail_t               pair01_f, pair23_f, trip_f, quad_f;
    logic [CODE_SLOTS-1:0]   fail_vec;
    logic [CODE_W-1:0]       pick;
    logic [CODE_W-1:0]       err_q;

    generate
        for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
            always_comb chunk_a[n] = chunk_i[n*CHUNK_W +: CHUNK_W];
            dsp_cfgchk_lane u_lane (
                .mono_i  (mono_i[n]),
                .chunk_i (chunk_a[n]),
                .bad_o   (lane_bad[n])
            );
        end
    endgenerate

    dsp_cfgchk_group #(.SIZE(2), .CHECK_CHUNK(1'b1)) u_pair01 (
        .en_i(en_i[1:0]), .mono_i(mono_i[1:0]), .chunk_lo_i(chunk_a[0]), .fail_o(pair01_f));
    dsp_cfgchk_group #(.SIZE(2), .CHECK_CHUNK(1'b1)) u_pair23 (
        .en_i(en_i[3:2]), .mono_i(mono_i[3:2]), .chunk_lo_i(chunk_a[2]), .fail_o(pair23_f));
    dsp_cfgchk_group #(.SIZE(3), .CHECK_CHUNK(1'b1)) u_trip (
        .en_i(en_i[2:0]), .mono_i(mono_i[2:0]), .chunk_lo_i(chunk_a[0]), .fail_o(trip_f));
    dsp_cfgchk_group #(.SIZE(4), .CHECK_CHUNK(1'b0)) u_quad (
        .en_i(en_i[3:0]), .mono_i(mono_i[3:0]), .chunk_lo_i(chunk_a[0]), .fail_o(quad_f));

    always_comb begin
        fail_vec = '0;
        case (mode_i)
            3'd0: begin
                fail_vec[M0_L0] = lane_bad[0];
                fail_vec[M0_L1] = lane_bad[1];
                fail_vec[M0_L2] = lane_bad[2];
                fail_vec[M0_L3] = lane_bad[3];
            end
            3'd1: begin
                fail_vec[M1_P01_EN]   = pair01_f.en_fail;
                fail_vec[M1_P01_MONO] = pair01_f.mono_fail;
                fail_vec[M1_P01_CHK]  = pair01_f.chunk_fail;
                fail_vec[M1_L2]       = lane_bad[2];
                fail_vec[M1_L3]       = lane_bad[3];
            end
            3'd2: begin
                fail_vec[M2_P01_EN]   = pair01_f.en_fail;
                fail_vec[M2_P01_MONO] = pair01_f.mono_fail;
                fail_vec[M2_P01_CHK]  = pair01_f.chunk_fail;
                fail_vec[M2_P23_EN]   = pair23_f.en_fail;
                fail_vec[M2_P23_MONO] = pair23_f.mono_fail;
                fail_vec[M2_P23_CHK]  = pair23_f.chunk_fail;
            end
            3'd3: begin
                fail_vec[M3_T012_EN]   = trip_f.en_fail;
                fail_vec[M3_T012_MONO] = trip_f.mono_fail;
                fail_vec[M3_T012_CHK]  = trip_f.chunk_fail;
                fail_vec[M3_L3]        = lane_bad[3];
            end
            3'd4: begin
                fail_vec[M4_Q_EN]   = quad_f.en_fail;
                fail_vec[M4_Q_MONO] = quad_f.mono_fail;
            end
            default: fail_vec[CFG_RSVD] = 1'b1;
        endcase
    end

    dsp_cfgchk_prio #(.WIDTH(CODE_SLOTS)) u_prio (
        .vec_i (fail_vec),
        .idx_o (pick)
    );

    always_ff @(posedge clk) begin
        if (rst)            err_q <= '0;
        else if (en_i == '0) err_q <= '0;
        else                err_q <= pick;
    end

    assign err_code_o = err_q;

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |=> (err_code_o == '0));
    a_r10_reserved_mode: assert property (@(posedge clk) disable iff (rst)
        ((mode_i > MODE_W'(MODE_MAX)) && (en_i != '0)) |=> (err_code_o == CFG_RSVD));
    a_r3_lane0_big_chunk: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == 3'd0) && (en_i != '0) && (chunk_i[CHUNK_W-1:0] == chunk_t'(CHUNK_BIG))) |=> (err_code_o == M0_L0));
    a_r8_quad_disabled: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == 3'd4) && (en_i != '0) && (en_i != '1)) |=> (err_code_o == M4_Q_EN));
    a_r11_code_range: assert property (@(posedge clk) disable iff (rst)
        (err_code_o <= CODE_W'(21)) || (err_code_o == CFG_RSVD));
endmodule

// File: tb/dsp_cfg_checker_tb.sv
module dsp_cfg_checker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd7;
    logic [3:0]  en_i = 4'hF;
    logic [3:0]  mono_i = 4'h0;
    logic [19:0] chunk_i = '0;
    logic [4:0]  err_code_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] exp;
        string      tag;
        int         due;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsp_cfg_checker u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .en_i(en_i),
        .mono_i(mono_i), .chunk_i(chunk_i), .err_code_o(err_code_o));

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [3:0] e, input logic [3:0] mo,
                         input logic [4:0] c0, input logic [4:0] c1,
                         input logic [4:0] c2, input logic [4:0] c3,
                         input logic [4:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        mode_i = m; en_i = e; mono_i = mo; chunk_i = {c3, c2, c1, c0};
        it.exp = exp; it.tag = tag; it.due = cyc + 1;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(err_code_o, it.exp, it.tag);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(err_code_o, 5'd0, "R1 reset state");
        rst = 1'b0;
        // R11 valid baseline
        drive(3'd0, 4'hF, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd0, "R11 valid mode0");
        // R3 single-lane rule
        drive(3'd0, 4'hF, 4'h0, 5'd4, 5'd4, 5'd16, 5'd4, 5'd3, "R3 lane2 chunk16");
        drive(3'd0, 4'hF, 4'h1, 5'd8, 5'd4, 5'd4, 5'd4, 5'd1, "R3 lane0 chunk8 mono");
        drive(3'd0, 4'hF, 4'h0, 5'd4, 5'd4, 5'd4, 5'd8, 5'd0, "R3 lane3 chunk8 stereo");
        drive(3'd0, 4'hF, 4'h2, 5'd4, 5'd8, 5'd4, 5'd4, 5'd2, "R3 lane1 chunk8 mono");
        drive(3'd0, 4'h1, 4'h0, 5'd4, 5'd4, 5'd4, 5'd16, 5'd4, "R3 lane3 ignores enable");
        drive(3'd0, 4'hF, 4'h0, 5'd4, 5'd16, 5'd4, 5'd16, 5'd2, "R9 two lanes bad");
        // R4 / R5 mode 1
        drive(3'd1, 4'hE, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd5, "R4 pair lane0 off");
        drive(3'd1, 4'hF, 4'h1, 5'd4, 5'd4, 5'd4, 5'd4, 5'd6, "R4 mono mismatch");
        drive(3'd1, 4'hF, 4'h3, 5'd4, 5'd4, 5'd4, 5'd4, 5'd0, "R4 both mono ok");
        drive(3'd1, 4'hF, 4'h0, 5'd16, 5'd4, 5'd4, 5'd4, 5'd7, "R4 chunk0 16");
        drive(3'd1, 4'hF, 4'h1, 5'd16, 5'd4, 5'd4, 5'd4, 5'd6, "R9 mono beats chunk");
        drive(3'd1, 4'hD, 4'h0, 5'd16, 5'd4, 5'd4, 5'd4, 5'd5, "R9 enable beats chunk");
        drive(3'd1, 4'hF, 4'h0, 5'd4, 5'd4, 5'd16, 5'd4, 5'd8, "R5 lane2 chunk16");
        drive(3'd1, 4'hF, 4'h8, 5'd4, 5'd4, 5'd4, 5'd8, 5'd9, "R5 lane3 chunk8 mono");
        // R6 mode 2
        drive(3'd2, 4'hD, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd10, "R6 pair01 off");
        drive(3'd2, 4'hF, 4'h1, 5'd4, 5'd4, 5'd4, 5'd4, 5'd11, "R6 pair01 mono");
        drive(3'd2, 4'hF, 4'h0, 5'd16, 5'd4, 5'd4, 5'd4, 5'd12, "R6 pair01 chunk");
        drive(3'd2, 4'hB, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd13, "R6 pair23 off");
        drive(3'd2, 4'hF, 4'h4, 5'd4, 5'd4, 5'd4, 5'd4, 5'd14, "R6 pair23 mono");
        drive(3'd2, 4'hF, 4'h0, 5'd4, 5'd4, 5'd16, 5'd4, 5'd15, "R6 pair23 chunk");
        drive(3'd2, 4'hF, 4'h0, 5'd4, 5'd16, 5'd4, 5'd16, 5'd0, "R6 upper chunks unchecked");
        // R7 mode 3
        drive(3'd3, 4'hB, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd16, "R7 triple off");
        drive(3'd3, 4'hF, 4'h3, 5'd4, 5'd4, 5'd4, 5'd4, 5'd17, "R7 triple mono");
        drive(3'd3, 4'hF, 4'h7, 5'd4, 5'd4, 5'd4, 5'd4, 5'd0, "R7 triple mono ok");
        drive(3'd3, 4'hF, 4'h0, 5'd16, 5'd4, 5'd4, 5'd4, 5'd18, "R7 triple chunk");
        drive(3'd3, 4'hF, 4'h0, 5'd4, 5'd4, 5'd4, 5'd16, 5'd19, "R7 lane3 chunk");
        drive(3'd3, 4'h7, 4'h0, 5'd4, 5'd16, 5'd4, 5'd4, 5'd0, "R7 lane3 off and chunk1 ok");
        // R8 mode 4
        drive(3'd4, 4'h7, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd20, "R8 quad off");
        drive(3'd4, 4'hF, 4'h7, 5'd4, 5'd4, 5'd4, 5'd4, 5'd21, "R8 quad mono");
        drive(3'd4, 4'hF, 4'hF, 5'd16, 5'd16, 5'd4, 5'd4, 5'd0, "R8 chunk unchecked");
        // R10 reserved modes
        drive(3'd5, 4'hF, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd31, "R10 mode5");
        drive(3'd7, 4'h2, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd31, "R10 mode7");
        // R2 all lanes off overrides
        drive(3'd7, 4'h0, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd0, "R2 reserved but idle");
        drive(3'd0, 4'h0, 4'h0, 5'd16, 5'd16, 5'd4, 5'd4, 5'd0, "R2 bad chunk but idle");
        // R11 clear after correction
        drive(3'd0, 4'hF, 4'h0, 5'd16, 5'd4, 5'd4, 5'd4, 5'd1, "R11 error set");
        drive(3'd0, 4'hF, 4'h0, 5'd4, 5'd4, 5'd4, 5'd4, 5'd0, "R11 error cleared");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R1: got %0d pending expected 0", q.size());
        end
        finish_run();
    end
endmodule